// File: doc/BRIEF.md
# Watchdog Timer with NMI Escalation

The block is a watchdog built on a 10-bit up-counter that advances once for every cycle in which the prescaled `tick` input is high and the watchdog is running. When the count reaches a programmable compare value, the counter wraps to zero. Depending on the response mode, the block then produces a one-cycle non-maskable interrupt pulse, a one-cycle reset request, or nothing. In the escalation mode, the first match raises an NMI and sets a status flag. If software has not cleared that flag by the next match, the block requests a reset.

Software uses two 16-bit registers, selected by a one-bit address.

**Control register (select 0):**
- Bits [3:0] hold the run key. Writing 0xA stops the watchdog and writing any other value starts it. Reading returns 0xA while stopped and 0x0 while running.
- Bit 4 is the service ("kick") strobe. Writing 1 clears the counter and the status flag.
- Bits [6:5] hold the response mode.
- Bit 7 is the read-only NMI status flag.

**Compare register (select 1):**
- Bits [9:0] hold the compare value.

Every write counts only while the `unlock` input is high. This models a protection scheme held outside the block.

Top module: `wdog_nmi_top`

## Requirements
- R1: After reset the compare value is 0x3FF, the mode is 0, the watchdog is stopped, the status flag is 0 and both pulse outputs are low. The control register reads 0x000A and the compare register reads 0x03FF.
- R2: While running, the counter rises by one in each cycle with `tick` high. It holds its value when `tick` is low or the watchdog is stopped.
- R3: A match is a `tick` cycle while running in which the count equals the compare value. On a match the counter returns to 0, and any response is a pulse exactly one clock long, high in the cycle after the match.
- R4: In mode 0 every match produces a pulse on `rst_req` and no NMI.
- R5: In mode 1 every match produces a pulse on `nmi_pulse` and sets the status flag (control bit 7).
- R6: In mode 2 a match with the status flag clear produces an NMI and sets the flag. A match with the flag set produces a reset request instead, and the flag stays set.
- R7: In mode 3 a match produces neither pulse and leaves the status flag unchanged.
- R8: An unlocked control write with bit 4 set clears the counter and the status flag. With bit 4 clear the write changes neither. Bit 4 always reads 0.
- R9: A clearing write in the same cycle as a match wins: that match produces no pulse and sets no flag.
- R10: An unlocked control write with bits [3:0] equal to 0xA stops counting, and any other value starts it. The run field reads 0xA when stopped and 0x0 when running.
- R11: With `unlock` low, writes to either register change nothing, including the clearing strobe.
- R12: Control bits [15:8] and compare bits [15:10] read as 0. The mode reads back in control bits [6:5].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled count enable |
| unlock | input | 1 | Write permission for both registers |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 compare |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read source: 0 control, 1 compare |
| rd_data | output | 16 | Read data (combinational) |
| nmi_pulse | output | 1 | One-cycle NMI request |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The count is hidden, so a wrong counter value shows up only as a match pulse appearing earlier or later than the bench's cycle model predicts. That difference appears at the first match after the fault, at most compare-value-plus-one ticks later. A wrong status flag or mode is visible in the very next control-register read. In escalation mode it also swaps an NMI for a reset at the following match. Because the reference model is compared on every clock, a misplaced pulse or a one-cycle lag in the registered outputs is reported in the cycle it happens.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int          WD_CNT_W   = 10;
  localparam int          WD_DATA_W  = 16;
  localparam int          KEY_W      = 4;
  localparam logic [3:0]  KEY_STOP   = 4'hA;
  localparam int          KICK_BIT   = 4;
  localparam int          MODE_LSB   = 5;
  localparam int          STAT_BIT   = 7;

  typedef enum logic [1:0] {
    MODE_RST  = 2'd0,
    MODE_NMI  = 2'd1,
    MODE_ESC  = 2'd2,
    MODE_NONE = 2'd3
  } resp_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_NMI  = 2'd1,
    ACT_RST  = 2'd2
  } resp_act_e;

  // Response chosen for a match, given the mode and the pending status flag.
  function automatic resp_act_e pick_action(resp_mode_e m, logic flag);
    case (m)
      MODE_RST: return ACT_RST;
      MODE_NMI: return ACT_NMI;
      MODE_ESC: return flag ? ACT_RST : ACT_NMI;
      default:  return ACT_NONE;
    endcase
  endfunction

  // Value returned in the run field.
  function automatic logic [KEY_W-1:0] key_readback(logic running);
    return running ? '0 : KEY_STOP;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W  = WD_CNT_W,
  parameter int DATA_W = WD_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unlock,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  input  logic              status,
  output logic [DATA_W-1:0] rd_data,
  output resp_mode_e        mode,
  output logic              running,
  output logic [CNT_W-1:0]  cmp,
  output logic              clr
);
  localparam int CTRL_W = STAT_BIT + 1;

  logic wr_ok, ctrl_wr, cmp_wr;
  logic [CTRL_W-1:0] ctrl_view;
  logic unused_wr_hi;

  assign wr_ok   = wr_en & unlock;
  assign ctrl_wr = wr_ok & ~wr_sel;
  assign cmp_wr  = wr_ok & wr_sel;
  assign clr     = ctrl_wr & wr_data[KICK_BIT];
  assign unused_wr_hi = ^wr_data[DATA_W-1:CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MODE_RST;
      running <= 1'b0;
      cmp     <= '1;
    end else begin
      if (ctrl_wr) begin
        mode    <= resp_mode_e'(wr_data[MODE_LSB +: 2]);
        running <= (wr_data[KEY_W-1:0] != KEY_STOP);
      end
      if (cmp_wr) cmp <= wr_data[CNT_W-1:0];
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[KEY_W-1:0]       = key_readback(running);
    ctrl_view[MODE_LSB +: 2]   = mode;
    ctrl_view[STAT_BIT]        = status;
    rd_data = '0;
    if (rd_sel) rd_data[CNT_W-1:0]  = cmp;
    else        rd_data[CTRL_W-1:0] = ctrl_view;
  end

  // R11: locked writes leave every field alone
  assert_locked_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlock) |=> ($stable(mode) && $stable(running) && $stable(cmp)));
  // R10: stop key halts, other keys start
  assert_stop_key_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unlock && !wr_sel && wr_data[KEY_W-1:0] == KEY_STOP) |=> !running);
  assert_run_key_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unlock && !wr_sel && wr_data[KEY_W-1:0] != KEY_STOP) |=> running);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = wdog_pkg::WD_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             running,
  input  logic [CNT_W-1:0] cmp,
  input  logic             clr,
  output logic             match_evt
);
  logic [CNT_W-1:0] count;
  logic             adv;

  function automatic logic [CNT_W-1:0] next_count(
    logic [CNT_W-1:0] cur, logic step, logic hit, logic wipe);
    if (wipe || hit) return '0;
    if (step)        return cur + 1'b1;
    return cur;
  endfunction

  assign adv       = tick & running;
  assign match_evt = adv & (count == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= next_count(count, adv, match_evt, clr);
  end

  // R3: a match returns the counter to zero
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> (count == '0));
  // R2: idle cycles hold the count
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(count));
  // R2: a plain tick adds one
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !match_evt && !clr) |=> (count == $past(count) + 1'b1));
  // R8: a clear zeroes the counter
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
endmodule

// File: rtl/wdog_resp.sv
module wdog_resp
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       match_evt,
  input  logic       clr,
  input  resp_mode_e mode,
  output logic       status,
  output logic       nmi_q,
  output logic       rst_q
);
  resp_act_e act;
  logic      fire;

  assign act  = pick_action(mode, status);
  assign fire = match_evt & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= 1'b0;
      nmi_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      nmi_q <= fire && (act == ACT_NMI);
      rst_q <= fire && (act == ACT_RST);
      if (clr)                            status <= 1'b0;
      else if (fire && act == ACT_NMI)    status <= 1'b1;
    end
  end

  // R4: never both responses at once
  assert_one_response_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_q && rst_q));
  // R5: an NMI pulse is always accompanied by the flag
  assert_nmi_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_q |-> status);
  // R6: pending flag in escalation mode turns a match into a reset
  assert_escalate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !clr && mode == MODE_ESC && status) |=> (rst_q && status));
  // R7: reserved mode stays silent
  assert_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && mode == MODE_NONE) |=> (!nmi_q && !rst_q && status == $past(status)));
  // R9: a clear beats a same-cycle match
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!nmi_q && !rst_q && !status));
  // R3: responses last one cycle for a single match
  assert_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_evt) |=> (!nmi_q && !rst_q));
endmodule

// File: rtl/wdog_nmi_top.sv
module wdog_nmi_top
  import wdog_pkg::*;
#(
  parameter int CNT_W  = WD_CNT_W,
  parameter int DATA_W = WD_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              unlock,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              nmi_pulse,
  output logic              rst_req
);
  resp_mode_e       mode;
  logic             running, clr, match_evt, status;
  logic [CNT_W-1:0] cmp;

  wdog_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .unlock(unlock), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .status(status), .rd_data(rd_data),
    .mode(mode), .running(running), .cmp(cmp), .clr(clr)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .running(running), .cmp(cmp),
    .clr(clr), .match_evt(match_evt)
  );

  wdog_resp u_resp (
    .clk(clk), .rst_n(rst_n), .match_evt(match_evt), .clr(clr), .mode(mode),
    .status(status), .nmi_q(nmi_pulse), .rst_q(rst_req)
  );

  // R1: nothing is requested in the first cycle after reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!nmi_pulse && !rst_req));
endmodule

// File: tb/sim_wdog_nmi_top.sv
module sim_wdog_nmi_top;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick = 1'b0, unlock = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        nmi_pulse, rst_req;

  int checks = 0, errors = 0, nmi_seen = 0, rst_seen = 0;
  bit done = 0;
  string phase = "R1";

  // reference model state
  int   m_cnt = 0, m_cmp = 1023, m_mode = 0;
  bit   m_run = 0, m_stat = 0, m_nmi = 0, m_rst = 0;

  wdog_nmi_top u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .unlock(unlock), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .nmi_pulse(nmi_pulse), .rst_req(rst_req)
  );

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 1023; m_mode = 0; m_run = 0; m_stat = 0; m_nmi = 0; m_rst = 0;
    end else begin
      bit ok, kick, hit, n_nmi, n_rst;
      ok   = wr_en && unlock;
      kick = ok && !wr_sel && wr_data[4];
      hit  = m_run && tick && (m_cnt == m_cmp);
      n_nmi = 0; n_rst = 0;
      if (hit && !kick) begin
        if (m_mode == 0) n_rst = 1;
        else if (m_mode == 1) begin n_nmi = 1; m_stat = 1; end
        else if (m_mode == 2) begin
          if (m_stat) n_rst = 1; else begin n_nmi = 1; m_stat = 1; end
        end
      end
      if (kick) m_stat = 0;
      if (kick || hit) m_cnt = 0;
      else if (m_run && tick) m_cnt = m_cnt + 1;
      if (ok && !wr_sel) begin
        m_mode = int'(wr_data[6:5]);
        m_run  = (wr_data[3:0] != 4'hA);
      end
      if (ok && wr_sel) m_cmp = int'(wr_data[9:0]);
      m_nmi = n_nmi; m_rst = n_rst;
    end
  end

  function automatic logic [15:0] model_rd(bit sel);
    logic [15:0] v;
    v = '0;
    if (sel) v[9:0] = m_cmp[9:0];
    else begin
      v[3:0] = m_run ? 4'h0 : 4'hA;
      v[6:5] = m_mode[1:0];
      v[7]   = m_stat;
    end
    return v;
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle of inputs, compare against the model before the edge
  task automatic step(input bit we, input bit sel, input logic [15:0] d,
                      input bit ul, input bit tk);
    wr_en = we; wr_sel = sel; wr_data = d; unlock = ul; tick = tk;
    rd_sel = ~rd_sel;
    #1;
    chk(rd_data, model_rd(rd_sel), {phase, " read"});
    chk({15'd0, nmi_pulse}, {15'd0, m_nmi}, {phase, " nmi"});
    chk({15'd0, rst_req},  {15'd0, m_rst}, {phase, " rst"});
    if (nmi_pulse) nmi_seen++;
    if (rst_req)   rst_seen++;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(input int n, input bit tk);
    for (int i = 0; i < n; i++) step(0, 0, 16'h0, 0, tk);
  endtask

  task automatic peek(input bit sel, input logic [15:0] exp, input string tag);
    rd_sel = sel; #1; chk(rd_data, exp, tag);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R12: reset values and layout
    peek(0, 16'h000A, "R1 ctrl");
    peek(1, 16'h03FF, "R1 cmp");
    chk({14'd0, nmi_pulse, rst_req}, 16'h0, "R1 outputs");

    // R11: locked writes, including a kick and a start key
    phase = "R11";
    step(1, 1, 16'h0004, 0, 1);
    step(1, 0, 16'h0033, 0, 1);
    idle(3, 1);
    peek(0, 16'h000A, "R11 ctrl");
    peek(1, 16'h03FF, "R11 cmp");

    // R4 / R2 / R3: mode 0, compare 5, tick always high
    phase = "R4";
    step(1, 1, 16'hFC05, 1, 0);
    peek(1, 16'h0005, "R12 cmp upper bits");
    step(1, 0, 16'h0013, 1, 0);
    peek(0, 16'h0000, "R10 running read");
    nmi_seen = 0; rst_seen = 0;
    idle(20, 1);
    chk(16'(rst_seen), 16'd3, "R4 reset count");
    chk(16'(nmi_seen), 16'd0, "R4 nmi count");

    // R2: irregular tick pattern
    phase = "R2";
    for (int i = 0; i < 40; i++) step(0, 0, 16'h0, 0, (i % 3) != 1);

    // R5 / R8: NMI mode, status, kick
    phase = "R5";
    step(1, 0, 16'h0033, 1, 0);
    nmi_seen = 0; rst_seen = 0;
    idle(8, 1);
    chk(16'(nmi_seen), 16'd1, "R5 nmi count");
    peek(0, 16'h00A0, "R5 status set");
    phase = "R8";
    step(1, 0, 16'h0023, 1, 0);
    peek(0, 16'h00A0, "R8 no-kick write keeps status");
    step(1, 0, 16'h0033, 1, 0);
    peek(0, 16'h0020, "R8 kick clears status");

    // R6: escalation
    phase = "R6";
    step(1, 0, 16'h0053, 1, 0);
    nmi_seen = 0; rst_seen = 0;
    idle(14, 1);
    chk(16'(nmi_seen), 16'd1, "R6 first nmi");
    chk(16'(rst_seen), 16'd1, "R6 escalated reset");
    peek(0, 16'h00C0, "R6 status stays");
    // regular servicing keeps it quiet
    phase = "R8";
    nmi_seen = 0; rst_seen = 0;
    for (int i = 0; i < 32; i++) step((i % 4) == 0, 0, 16'h0053, 1, 1);
    chk(16'(nmi_seen + rst_seen), 16'd0, "R8 serviced no pulses");

    // R9: kick exactly on the matching tick
    phase = "R9";
    step(1, 0, 16'h0033, 1, 0);
    for (int i = 0; i < 20 && !(m_run && m_cnt == m_cmp); i++) idle(1, 1);
    step(1, 0, 16'h0033, 1, 1);
    chk({14'd0, nmi_pulse, rst_req}, 16'h0, "R9 no pulse");
    peek(0, 16'h0020, "R9 no status");

    // R7: reserved mode
    phase = "R7";
    step(1, 0, 16'h0073, 1, 0);
    nmi_seen = 0; rst_seen = 0;
    idle(20, 1);
    chk(16'(nmi_seen + rst_seen), 16'd0, "R7 silent");

    // R10: stop key, then restart with 0xF, hold on tick low
    phase = "R10";
    step(1, 0, 16'h000A, 1, 0);
    nmi_seen = 0; rst_seen = 0;
    idle(15, 1);
    chk(16'(rst_seen), 16'd0, "R10 stopped no pulses");
    peek(0, 16'h000A, "R10 stopped read");
    step(1, 0, 16'h001F, 1, 0);
    idle(10, 0);
    idle(8, 1);
    chk(16'(rst_seen), 16'd1, "R10 restarted reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule